// File: doc/BRIEF.md
# PCI Master Command Selector

This block sits inside a bus-master DMA engine and chooses the PCI bus command that goes on the command/byte-enable lines during the address phase of each transaction. For reads it picks plain Memory Read, Memory Read Line or Memory Read Multiple. For writes it picks plain Memory Write or Memory Write and Invalidate. It upgrades to a cache-line command only when the cache line size setting can be trusted and the transfer actually starts on a line boundary.

The DMA engine raises a one-cycle request strobe together with the direction, the start address and the current FIFO byte count. The configuration bits, the cache line size (in Dwords) and the programmed burst size (in Dwords) are sampled on the same edge. One cycle later the block presents the chosen 4-bit command with a one-cycle valid pulse. The command stays on the output until the next request.

Top module: `pci_cmd_sel`

## Requirements
- R1: While rst_ni is low, cmd_o is 4'b0000 and cmd_valid_o is 0.
- R2: A request sampled high on a clock edge produces cmd_valid_o high for exactly the following cycle. With no request, cmd_valid_o stays low and cmd_o keeps its last value.
- R3: A write issues Memory Write (4'b0111) unless every write-upgrade condition holds, in which case it issues Memory Write and Invalidate (4'b1111). A write never issues any other code.
- R4: Memory Write and Invalidate requires the cache line enable, the write-invalidate enable and the config-command invalidate bit to all be set. Clearing any one of them yields 4'b0111.
- R5: The cache line size counts as legal only at 2, 4, 8, 16, 32, 64 or 128 Dwords. Any other value blocks every cache-line command.
- R6: A cache-line command is issued only when the cache line size is less than or equal to the burst size in Dwords. Equality is allowed.
- R7: Memory Write and Invalidate requires the FIFO byte count to be at least four times the cache line size. Exactly equal is enough. One byte less yields 4'b0111.
- R8: A cache-line command is issued only when the address bits below log2(cache line size x 4) are all zero.
- R9: For a read with the line conditions met (enable set, legal size, size within burst, aligned start) and read-multiple mode on, the command is Memory Read Multiple (4'b1100), whether or not read-line mode is on.
- R10: For a read with the line conditions met, read-line mode on and read-multiple mode off, the command is Memory Read Line (4'b1110).
- R11: Any other read issues Memory Read (4'b0110). A read never yields 4'b0111 or 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, samples all other inputs |
| write_i | input | 1 | 1 = write transaction, 0 = read |
| cls_en_i | input | 1 | Cache line size use enable |
| wr_inv_en_i | input | 1 | Write-and-invalidate enable from the DMA control register |
| cfg_inv_i | input | 1 | Invalidate-enable bit of the PCI config command register |
| rd_line_en_i | input | 1 | Read-line mode enable |
| rd_mult_en_i | input | 1 | Read-multiple mode enable |
| cls_dw_i | input | CLS_W (8) | Cache line size in Dwords |
| burst_dw_i | input | BURST_W (9) | Programmed burst size in Dwords |
| fifo_bytes_i | input | FIFO_W (12) | Bytes currently held in the DMA FIFO |
| addr_i | input | ADDR_W (32) | Transfer start byte address |
| cmd_o | output | 4 | Selected PCI bus command |
| cmd_valid_o | output | 1 | One-cycle pulse marking a new command |

## Verification
The hardest case to reach is an upgraded command. It needs a legal power-of-two line size, a burst at least that large, an address whose low bits are all clear and, for writes, a FIFO count at or above the line length, all on the same request. Uniform random inputs almost never line these up. So the random generator draws the line size mostly from the legal set, builds aligned addresses by masking, and sets the burst and FIFO count relative to the drawn line size. Directed cases then break one condition at a time right at its boundary: FIFO count one byte short, burst one Dword short, address one byte off, and neighbouring illegal sizes.

// File: rtl/pci_cmd_pkg.sv
package pci_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NONE    = 4'b0000,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_RD_MULT = 4'b1100,
    CMD_RD_LINE = 4'b1110,
    CMD_WR_INV  = 4'b1111
  } pci_cmd_e;

  typedef struct packed {
    logic line_ok;  // legal size, within burst, aligned
    logic fifo_ok;  // fifo holds a full line
  } line_qual_t;
endpackage

// File: rtl/pci_cl_qual.sv
module pci_cl_qual
  import pci_cmd_pkg::*;
#(
  parameter int CLS_W   = 8,
  parameter int BURST_W = 9,
  parameter int FIFO_W  = 12,
  parameter int ADDR_W  = 32,
  parameter int MAX_LOG = 7
) (
  input  logic               cls_en_i,
  input  logic [CLS_W-1:0]   cls_dw_i,
  input  logic [BURST_W-1:0] burst_dw_i,
  input  logic [FIFO_W-1:0]  fifo_bytes_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output line_qual_t         qual_o
);
  localparam int LB_W  = CLS_W + 2;
  localparam int CMP_W = CLS_W + BURST_W;
  localparam int FC_W  = (FIFO_W > LB_W) ? FIFO_W : LB_W;

  logic [MAX_LOG-1:0] size_hit;
  logic               legal;
  logic [LB_W-1:0]    line_bytes;
  logic [LB_W-1:0]    line_mask;
  logic               aligned;
  logic               fits_burst;

  // one comparator per legal power of two (2..2^MAX_LOG Dwords)
  for (genvar k = 1; k <= MAX_LOG; k++) begin : g_size
    assign size_hit[k-1] = (cls_dw_i == CLS_W'(1 << k));
  end

  assign legal      = |size_hit;
  assign line_bytes = {cls_dw_i, 2'b00};
  assign line_mask  = line_bytes - LB_W'(1);
  assign aligned    = ((addr_i[LB_W-1:0] & line_mask) == '0);
  assign fits_burst = (CMP_W'(cls_dw_i) <= CMP_W'(burst_dw_i));

  assign qual_o.line_ok = cls_en_i & legal & fits_burst & aligned;
  assign qual_o.fifo_ok = (FC_W'(fifo_bytes_i) >= FC_W'(line_bytes));
endmodule

// File: rtl/pci_cmd_pick.sv
module pci_cmd_pick
  import pci_cmd_pkg::*;
(
  input  logic       write_i,
  input  logic       wr_inv_en_i,
  input  logic       cfg_inv_i,
  input  logic       rd_line_en_i,
  input  logic       rd_mult_en_i,
  input  line_qual_t qual_i,
  output pci_cmd_e   cmd_o
);
  always_comb begin
    if (write_i) begin
      if (qual_i.line_ok && qual_i.fifo_ok && wr_inv_en_i && cfg_inv_i)
        cmd_o = CMD_WR_INV;
      else
        cmd_o = CMD_MEM_WR;
    end else if (qual_i.line_ok && rd_mult_en_i) begin
      cmd_o = CMD_RD_MULT;  // multiple wins over line
    end else if (qual_i.line_ok && rd_line_en_i) begin
      cmd_o = CMD_RD_LINE;
    end else begin
      cmd_o = CMD_MEM_RD;
    end
  end
endmodule

// File: rtl/pci_cmd_sel.sv
module pci_cmd_sel
  import pci_cmd_pkg::*;
#(
  parameter int CLS_W   = 8,
  parameter int BURST_W = 9,
  parameter int FIFO_W  = 12,
  parameter int ADDR_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               write_i,
  input  logic               cls_en_i,
  input  logic               wr_inv_en_i,
  input  logic               cfg_inv_i,
  input  logic               rd_line_en_i,
  input  logic               rd_mult_en_i,
  input  logic [CLS_W-1:0]   cls_dw_i,
  input  logic [BURST_W-1:0] burst_dw_i,
  input  logic [FIFO_W-1:0]  fifo_bytes_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [3:0]         cmd_o,
  output logic               cmd_valid_o
);
  localparam int MAX_LOG = 7;

  line_qual_t qual;
  pci_cmd_e   cmd_next;
  logic [3:0] cmd_q;
  logic       valid_q;

  pci_cl_qual #(
    .CLS_W(CLS_W), .BURST_W(BURST_W), .FIFO_W(FIFO_W),
    .ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)
  ) u_qual (
    .cls_en_i    (cls_en_i),
    .cls_dw_i    (cls_dw_i),
    .burst_dw_i  (burst_dw_i),
    .fifo_bytes_i(fifo_bytes_i),
    .addr_i      (addr_i),
    .qual_o      (qual)
  );

  pci_cmd_pick u_pick (
    .write_i     (write_i),
    .wr_inv_en_i (wr_inv_en_i),
    .cfg_inv_i   (cfg_inv_i),
    .rd_line_en_i(rd_line_en_i),
    .rd_mult_en_i(rd_mult_en_i),
    .qual_i      (qual),
    .cmd_o       (cmd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) cmd_q <= cmd_next;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_valid_o = valid_q;

  // R2: pulse follows request by one cycle, command holds between requests
  p_valid_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> cmd_valid_o);
  p_no_spurious_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !cmd_valid_o && $stable(cmd_o));
  // R3: writes only ever produce the two write codes
  p_write_codes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && write_i |=> (cmd_o == 4'b0111) || (cmd_o == 4'b1111));
  // R4: invalidate needs all three enables
  p_inv_enables_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && write_i && !(cls_en_i && wr_inv_en_i && cfg_inv_i) |=> cmd_o == 4'b0111);
  // R7: invalidate needs a full line in the fifo
  p_inv_fifo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && write_i && (32'(fifo_bytes_i) < 32'(cls_dw_i) * 4) |=> cmd_o == 4'b0111);
  // R9: read-multiple mode must be on for a multiple command
  p_mult_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !write_i && !rd_mult_en_i |=> cmd_o != 4'b1100);
  // R10: read line only when line mode on and multiple mode off
  p_line_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !write_i && (rd_mult_en_i || !rd_line_en_i) |=> cmd_o != 4'b1110);
  // R11: reads never produce write codes
  p_read_codes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !write_i |=> (cmd_o != 4'b0111) && (cmd_o != 4'b1111));
  // R1: reset state
  always_comb begin
    if (!rst_ni) p_reset_state_r1: assert (cmd_q == 4'b0000 && !valid_q);
  end
endmodule

// File: tb/tb_pci_cmd_sel.sv
`timescale 1ns/1ps
module tb_pci_cmd_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        write_i = 1'b0;
  logic        cls_en_i = 1'b0;
  logic        wr_inv_en_i = 1'b0;
  logic        cfg_inv_i = 1'b0;
  logic        rd_line_en_i = 1'b0;
  logic        rd_mult_en_i = 1'b0;
  logic [7:0]  cls_dw_i = '0;
  logic [8:0]  burst_dw_i = '0;
  logic [11:0] fifo_bytes_i = '0;
  logic [31:0] addr_i = '0;
  logic [3:0]  cmd_o;
  logic        cmd_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  pci_cmd_sel dut (.*);

  function automatic logic [3:0] exp_cmd(
    bit wr, bit cen, bit wie, bit cie, bit rl, bit rm,
    int cls, int burst, int fifo, logic [31:0] addr);
    bit legal = (cls == 2 || cls == 4 || cls == 8 || cls == 16 ||
                 cls == 32 || cls == 64 || cls == 128);
    bit ok = 0;
    if (legal) ok = cen && (cls <= burst) && ((addr % (cls * 4)) == 0);
    if (wr) return (ok && wie && cie && fifo >= cls * 4) ? 4'b1111 : 4'b0111;
    if (ok && rm) return 4'b1100;
    if (ok && rl) return 4'b1110;
    return 4'b0110;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, check pulse and hold
  task automatic run(string req, bit wr, bit cen, bit wie, bit cie, bit rl, bit rm,
                     int cls, int burst, int fifo, logic [31:0] addr);
    logic [3:0] e = exp_cmd(wr, cen, wie, cie, rl, rm, cls, burst, fifo, addr);
    write_i = wr; cls_en_i = cen; wr_inv_en_i = wie; cfg_inv_i = cie;
    rd_line_en_i = rl; rd_mult_en_i = rm;
    cls_dw_i = 8'(cls); burst_dw_i = 9'(burst); fifo_bytes_i = 12'(fifo); addr_i = addr;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(cmd_valid_o == 1'b1, "R2 valid", int'(cmd_valid_o), 1);
    check(cmd_o == e, req, int'(cmd_o), int'(e));
    write_i = ~wr; addr_i = addr ^ 32'h4;  // disturb inputs without request
    @(negedge clk_i);
    check(cmd_valid_o == 1'b0, "R2 pulse", int'(cmd_valid_o), 0);
    check(cmd_o == e, "R2 hold", int'(cmd_o), int'(e));
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1d2c;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    check(cmd_o == 4'b0000 && cmd_valid_o == 1'b0, "R1 reset", int'(cmd_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3/R4: full upgrade, then drop each enable
    run("R3 mwi",        1, 1, 1, 1, 0, 0, 16, 16, 64, 32'h100);
    run("R4 no cls_en",  1, 0, 1, 1, 0, 0, 16, 16, 64, 32'h100);
    run("R4 no wr_inv",  1, 1, 0, 1, 0, 0, 16, 16, 64, 32'h100);
    run("R4 no cfg_inv", 1, 1, 1, 0, 0, 0, 16, 16, 64, 32'h100);
    // R5: legality
    run("R5 cls 3",      1, 1, 1, 1, 0, 0, 3, 64, 4000, 32'h0);
    run("R5 cls 0",      0, 1, 0, 0, 1, 1, 0, 64, 4000, 32'h0);
    run("R5 cls 255",    0, 1, 0, 0, 1, 1, 255, 256, 4000, 32'h0);
    run("R5 cls 128",    1, 1, 1, 1, 0, 0, 128, 256, 512, 32'h400);
    run("R5 cls 2",      0, 1, 0, 0, 0, 1, 2, 2, 0, 32'h8);
    // R6: burst bound
    run("R6 equal",      0, 1, 0, 0, 1, 0, 32, 32, 0, 32'h80);
    run("R6 short",      0, 1, 0, 0, 1, 0, 32, 31, 0, 32'h80);
    // R7: fifo boundary
    run("R7 exact",      1, 1, 1, 1, 0, 0, 8, 8, 32, 32'h20);
    run("R7 one short",  1, 1, 1, 1, 0, 0, 8, 8, 31, 32'h20);
    // R8: alignment
    run("R8 off by one", 1, 1, 1, 1, 0, 0, 8, 8, 64, 32'h21);
    run("R8 half line",  0, 1, 0, 0, 0, 1, 8, 8, 0, 32'h10);
    // R9/R10/R11: read priority
    run("R9 both modes", 0, 1, 0, 0, 1, 1, 16, 16, 0, 32'h40);
    run("R9 mult only",  0, 1, 0, 0, 0, 1, 16, 16, 0, 32'h40);
    run("R10 line only", 0, 1, 0, 0, 1, 0, 16, 16, 0, 32'h40);
    run("R11 no modes",  0, 1, 1, 1, 0, 0, 16, 16, 4000, 32'h40);

    for (int i = 0; i < 400; i++) begin
      int cls, burst, fifo, lb;
      logic [31:0] a;
      bit wr = 1'($urandom);
      if ($urandom_range(3) != 0) cls = 1 << $urandom_range(7, 1);
      else cls = $urandom_range(255);
      lb = (cls == 0) ? 4 : cls * 4;
      burst = cls + $urandom_range(8) - 3;
      if (burst < 0) burst = 0;
      fifo = lb + $urandom_range(8) - 4;
      if (fifo < 0) fifo = 0;
      if (fifo > 4095) fifo = 4095;
      a = $urandom;
      if ($urandom_range(3) != 0) a = (a / lb) * lb;
      run(wr ? "R3 random write" : "R11 random read", wr,
          $urandom_range(7) != 0, $urandom_range(3) != 0, $urandom_range(3) != 0,
          1'($urandom), 1'($urandom), cls, burst, fifo, a);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule